// File: doc/BRIEF.md
# Shift-Register Reload Clock Divider

This block divides its input clock with linear feedback shift registers in place of binary counters. Each divider register walks a fixed pseudo-random sequence, one state per input clock. When it reaches the terminal state (all ones) it reloads from a reload register and flips its divided output. The divide ratio is therefore chosen by writing the sequence state that lies the right number of steps before the terminal state, not by writing a binary count.

Two such dividers are instantiated. A 6-bit reference divider covers ratios 1 to 64. An 8-bit feedback divider covers ratios 2 to 256 in normal use. Beside them, a chain of two cascaded binary post-divide stages, each dividing by 1 to 8, produces a third divided output. All ratios are programmed through a small write-only register port: a write strobe, a 2-bit address and 8 data bits. A new ratio never cuts short the half-period already in progress.

The recommended operating window is a feedback ratio of 5 to 256 and a reference ratio of 3 to 40. The post-divide is pd1 times pd2, with pd2 no larger than pd1. The block does not enforce this window; staying inside it is up to the software that programs the ratios.

Top module: `lfsr_clk_div_top`

## Requirements
- R1: While rst_ni is low, all three outputs are 0, both dividers sit at the terminal state, both reload registers hold 0x00 and the post code holds 0x3f. On the first rising edge after reset is released, all three outputs go to 1.
- R2: Each divider steps as follows. The all-zero state goes to the all-ones terminal state. Any other state shifts left by one bit, and the new bit 0 is the XNOR of the tap bits: bits 5 and 4 for the reference divider, bits 7, 5, 4 and 3 for the feedback divider. The reference reload value 0x15 gives a ratio of 8.
- R3: On every edge at which a divider is in the terminal state, it loads its reload register and inverts its output. On all other edges the output holds. The output therefore inverts every N clocks, where N is one more than the number of steps from the reload value to the terminal state. Reference reload 0x3f gives N=1, 0x00 gives N=2 and 0x20 gives N=3.
- R4: Feedback reload 0x00 gives a ratio of 2, 0x80 gives 3 and 0x01 gives 256.
- R5: Reference reload 0x01 gives the largest ratio, 64.
- R6: A reload write takes effect only at the divider's next terminal event. The half-period in progress keeps its old length, and a terminal event on the same edge as a write loads the old value.
- R7: The post code holds (8 - pd1) in bits 5:3 and (8 - pd2) in bits 2:0. post_clk_o inverts every pd1*pd2 clocks.
- R8: Each post stage picks up its new divisor only at its own terminal event. The second stage advances only on terminal events of the first stage.
- R9: Writes are decoded by address. Address 0 writes the reference reload from data bits 5:0, with bits 7:6 ignored. Address 1 writes the feedback reload from bits 7:0. Address 2 writes the post code from bits 5:0. Address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 8 | Write data |
| ref_clk_o | output | 1 | Reference divider output |
| fb_clk_o | output | 1 | Feedback divider output |
| post_clk_o | output | 1 | Output of the two cascaded post stages |

## Verification
Every output is registered. An output flip therefore appears on the same rising edge at which its divider or stage sits at its terminal count. A write made before an edge is sampled on that edge, but a divider only uses it at its next terminal event, so a new ratio can take up to one old half-period to appear. The reference model sees the same edges, applies a write after it has evaluated that edge's terminal event, and is compared with the outputs at every falling edge. The directed period measurements discard the first half-period after each write, except in the check that is specifically about the deferred reload.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  typedef enum logic [1:0] {
    ADDR_REF_RELOAD = 2'd0,
    ADDR_FB_RELOAD  = 2'd1,
    ADDR_POST_CODE  = 2'd2,
    ADDR_SPARE      = 2'd3
  } div_addr_e;

  localparam int unsigned NUM_POST_STAGES = 2;

endpackage

// File: rtl/lfsr_div_regs.sv
module lfsr_div_regs
  import lfsr_div_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REF_W  = 6,
  parameter int unsigned FB_W   = 8,
  parameter int unsigned PD_W   = 3,
  parameter logic [REF_W-1:0]  REF_RST  = '0,
  parameter logic [FB_W-1:0]   FB_RST   = '0,
  parameter logic [2*PD_W-1:0] CODE_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [REF_W-1:0]  ref_reload_o,
  output logic [FB_W-1:0]   fb_reload_o,
  output logic [2*PD_W-1:0] post_code_o
);

  localparam int unsigned CODE_W = 2 * PD_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_reload_o <= REF_RST;
      fb_reload_o  <= FB_RST;
      post_code_o  <= CODE_RST;
    end else if (wr_en_i) begin
      case (div_addr_e'(wr_addr_i))
        ADDR_REF_RELOAD: ref_reload_o <= wr_data_i[REF_W-1:0];
        ADDR_FB_RELOAD:  fb_reload_o  <= wr_data_i[FB_W-1:0];
        ADDR_POST_CODE:  post_code_o  <= wr_data_i[CODE_W-1:0];
        default: ;
      endcase
    end
  end

  // R9: the spare address leaves every setting untouched
  assert_spare_addr_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3) |=>
      ($stable(ref_reload_o) && $stable(fb_reload_o) && $stable(post_code_o)));

  // R6: no write strobe, no change in any reload register
  assert_regs_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(ref_reload_o) && $stable(fb_reload_o)));

endmodule

// File: rtl/lfsr_reload_div.sv
module lfsr_reload_div #(
  parameter int unsigned     WIDTH      = 6,
  parameter logic [WIDTH-1:0] TAPS      = 6'h30,
  parameter logic [WIDTH-1:0] RST_RELOAD = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] reload_i,
  output logic             div_o
);

  localparam logic [WIDTH-1:0] TERM_STATE = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO_STATE = {WIDTH{1'b0}};

  logic [WIDTH-1:0] state_q, state_step;
  logic             at_term;

  assign at_term = (state_q == TERM_STATE);

  // all-zero jumps straight to terminal, giving a 2^WIDTH-long chain
  always_comb begin
    if (state_q == ZERO_STATE) state_step = TERM_STATE;
    else state_step = {state_q[WIDTH-2:0], ~^(state_q & TAPS)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TERM_STATE;
      div_o   <= 1'b0;
    end else if (at_term) begin
      state_q <= reload_i;
      div_o   <= ~div_o;
    end else begin
      state_q <= state_step;
    end
  end

  assert_toggle_on_term_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_term |=> (div_o != $past(div_o)));

  assert_hold_off_term_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_term |=> $stable(div_o));

  // R6: the reload register is consumed only at a terminal event
  assert_reload_at_term_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_term |=> (state_q == $past(reload_i)));

  // R2: no lockup, terminal persists only when reloaded with itself
  assert_no_lockup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_term && reload_i != TERM_STATE) |=> (state_q != TERM_STATE));

endmodule

// File: rtl/post_div_stage.sv
module post_div_stage #(
  parameter int unsigned PD_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PD_W-1:0] code_i,
  output logic            tick_o
);

  logic [PD_W-1:0] cnt_q;

  // divisor is 2^PD_W - code, so the reload count (divisor - 1) is ~code
  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_o) cnt_q <= ~code_i;
    else if (en_i) cnt_q <= cnt_q - PD_W'(1);
  end

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));

  assert_code_latched_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == ~$past(code_i)));

endmodule

// File: rtl/lfsr_clk_div_top.sv
module lfsr_clk_div_top
  import lfsr_div_pkg::*;
#(
  parameter int unsigned REF_W  = 6,
  parameter int unsigned FB_W   = 8,
  parameter int unsigned PD_W   = 3,
  parameter int unsigned DATA_W = 8,
  parameter logic [REF_W-1:0] REF_TAPS = 6'h30,
  parameter logic [FB_W-1:0]  FB_TAPS  = 8'hB8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              ref_clk_o,
  output logic              fb_clk_o,
  output logic              post_clk_o
);

  localparam int unsigned NPS    = NUM_POST_STAGES;
  localparam int unsigned CODE_W = NPS * PD_W;

  logic [REF_W-1:0]  ref_reload;
  logic [FB_W-1:0]   fb_reload;
  logic [CODE_W-1:0] post_code;
  logic [NPS-1:0]    st_en, st_tick;

  lfsr_div_regs #(
    .DATA_W(DATA_W), .REF_W(REF_W), .FB_W(FB_W), .PD_W(PD_W),
    .REF_RST('0), .FB_RST('0), .CODE_RST('1)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ref_reload_o(ref_reload), .fb_reload_o(fb_reload), .post_code_o(post_code)
  );

  lfsr_reload_div #(.WIDTH(REF_W), .TAPS(REF_TAPS), .RST_RELOAD('0)) u_ref_div (
    .clk_i, .rst_ni, .reload_i(ref_reload), .div_o(ref_clk_o)
  );

  lfsr_reload_div #(.WIDTH(FB_W), .TAPS(FB_TAPS), .RST_RELOAD('0)) u_fb_div (
    .clk_i, .rst_ni, .reload_i(fb_reload), .div_o(fb_clk_o)
  );

  // stage 0 runs every clock; each later stage runs on the previous stage's tick
  assign st_en = {st_tick[NPS-2:0], 1'b1};

  for (genvar g = 0; g < NPS; g++) begin : g_post
    post_div_stage #(.PD_W(PD_W)) u_stage (
      .clk_i, .rst_ni,
      .en_i  (st_en[g]),
      .code_i(post_code[(NPS-g)*PD_W-1 -: PD_W]),
      .tick_o(st_tick[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) post_clk_o <= 1'b0;
    else if (st_tick[NPS-1]) post_clk_o <= ~post_clk_o;
  end

  assert_post_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_tick[NPS-1] |=> (post_clk_o != $past(post_clk_o)));

  assert_post_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_tick[NPS-1] |=> $stable(post_clk_o));

endmodule

// File: tb/lfsr_clk_div_top_bench.sv
module lfsr_clk_div_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       ref_clk, fb_clk, post_clk;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_clk_div_top u_lfsr_clk_div_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ref_clk_o(ref_clk), .fb_clk_o(fb_clk),
    .post_clk_o(post_clk)
  );

  // ratio tables built by walking the sequence defined in R2
  int ref_ratio [64];
  int fb_ratio  [256];
  int fb_reload_for [257];

  function automatic logic [5:0] step6(logic [5:0] s);
    if (s == 6'd0) return 6'h3f;
    return {s[4:0], ~(s[5] ^ s[4])};
  endfunction

  function automatic logic [7:0] step8(logic [7:0] s);
    if (s == 8'd0) return 8'hff;
    return {s[6:0], ~(s[7] ^ s[5] ^ s[4] ^ s[3])};
  endfunction

  initial begin
    logic [5:0] s6;
    logic [7:0] s8;
    s6 = 6'h01;
    for (int d = 64; d >= 1; d--) begin ref_ratio[s6] = d; s6 = step6(s6); end
    s8 = 8'h01;
    for (int d = 256; d >= 1; d--) begin
      fb_ratio[s8] = d; fb_reload_for[d] = s8; s8 = step8(s8);
    end
  end

  // behavioural model: cycles remaining until each unit's next terminal event
  int rem_ref, rem_fb, rem_p1, rem_p2;
  bit exp_ref, exp_fb, exp_post;
  logic [5:0] m_ref;
  logic [7:0] m_fb;
  logic [5:0] m_code;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_ref = 1; rem_fb = 1; rem_p1 = 1; rem_p2 = 1;
      exp_ref = 0; exp_fb = 0; exp_post = 0;
      m_ref = 6'h00; m_fb = 8'h00; m_code = 6'h3f;
    end else begin
      if (rem_ref == 1) begin exp_ref = ~exp_ref; rem_ref = ref_ratio[m_ref]; end
      else rem_ref--;
      if (rem_fb == 1) begin exp_fb = ~exp_fb; rem_fb = fb_ratio[m_fb]; end
      else rem_fb--;
      if (rem_p1 == 1) begin
        rem_p1 = 8 - int'(m_code[5:3]);
        if (rem_p2 == 1) begin exp_post = ~exp_post; rem_p2 = 8 - int'(m_code[2:0]); end
        else rem_p2--;
      end else rem_p1--;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_ref = wr_data[5:0];
          2'd1: m_fb = wr_data;
          2'd2: m_code = wr_data[5:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(ref_clk == exp_ref, "R2 R3 ref_clk_o vs model", int'(ref_clk), int'(exp_ref));
      check(fb_clk == exp_fb, "R4 fb_clk_o vs model", int'(fb_clk), int'(exp_fb));
      check(post_clk == exp_post, "R7 R8 post_clk_o vs model", int'(post_clk), int'(exp_post));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return ref_clk;
      1: return fb_clk;
      default: return post_clk;
    endcase
  endfunction

  // cycles between two consecutive output flips, seen at falling edges
  task automatic half_period(input int sel, output int n);
    logic prev;
    prev = pick(sel);
    do @(negedge clk); while (pick(sel) == prev);
    prev = pick(sel);
    n = 0;
    do begin @(negedge clk); n++; end while (pick(sel) == prev);
  endtask

  task automatic settle_measure(input int sel, input int exp, input string tag);
    int n;
    half_period(sel, n);
    half_period(sel, n);
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    int n;
    logic prev;
    repeat (3) @(negedge clk);
    check(ref_clk == 0 && fb_clk == 0 && post_clk == 0, "R1 outputs low in reset",
          int'({ref_clk, fb_clk, post_clk}), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    check(ref_clk && fb_clk && post_clk, "R1 all outputs high after first edge",
          int'({ref_clk, fb_clk, post_clk}), 7);
    settle_measure(0, 2, "R1 default ref ratio");
    settle_measure(1, 2, "R4 default fb ratio 0x00");
    settle_measure(2, 1, "R7 default post code 0x3f");

    wr(2'd0, 8'h3f); settle_measure(0, 1, "R3 ref reload 0x3f");
    wr(2'd0, 8'h00); settle_measure(0, 2, "R3 ref reload 0x00");
    wr(2'd0, 8'h20); settle_measure(0, 3, "R3 ref reload 0x20");
    wr(2'd0, 8'h15); settle_measure(0, 8, "R2 ref reload 0x15");
    wr(2'd0, 8'h01); settle_measure(0, 64, "R5 ref reload 0x01");

    wr(2'd1, 8'h80); settle_measure(1, 3, "R4 fb reload 0x80");
    wr(2'd1, 8'h01); settle_measure(1, 256, "R4 fb reload 0x01");
    wr(2'd1, 8'(fb_reload_for[100])); settle_measure(1, 100, "R2 fb ratio 100");

    wr(2'd2, 8'h2e); settle_measure(2, 6, "R7 post pd1=3 pd2=2");
    wr(2'd2, 8'h07); settle_measure(2, 8, "R7 post pd1=8 pd2=1");
    wr(2'd2, 8'h00); settle_measure(2, 64, "R8 post pd1=8 pd2=8");
    wr(2'd2, 8'h36); settle_measure(2, 4, "R7 post pd1=2 pd2=2");

    // R9: spare address and upper data bits
    wr(2'd0, 8'h20); settle_measure(0, 3, "R9 ref set to 3");
    wr(2'd3, 8'h3f); settle_measure(0, 3, "R9 spare write leaves ref");
    settle_measure(2, 4, "R9 spare write leaves post");
    wr(2'd0, 8'hd5); settle_measure(0, 8, "R9 ref ignores data bits 7:6");

    // R6: write mid half-period, old length must finish
    wr(2'd0, 8'h01); settle_measure(0, 64, "R6 ref back to 64");
    prev = ref_clk;
    do @(negedge clk); while (ref_clk == prev);
    prev = ref_clk;
    repeat (5) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h3f;
    @(negedge clk);
    wr_en = 1'b0;
    n = 6;
    while (ref_clk == prev) begin @(negedge clk); n++; end
    check(n == 64, "R6 half-period in progress keeps old ratio", n, 64);
    half_period(0, n);
    check(n == 1, "R6 new ratio after terminal event", n, 1);

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual %0d expected 0", MAX_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule